// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the control unit of a processor that completes one instruction per clock. It is purely combinational. It looks at the primary opcode and function fields of the instruction word, the active-low reset level, the interrupt request and the zero flag from the ALU. From these it produces every select and enable that steers the datapath: the next-PC source, immediate extension, register write address and data sources, the ALU function, the two write enables and the two ALU operand selects.

Internally the decode is a fixed table keyed by instruction class. Reset and interrupt sit above that table in a strict priority order. An opcode or function value outside the supported set does not fall through as a no-op. It is turned into a trap that jumps to a dedicated vector and saves the return address in register 27.

Top module: `cpu_ctl_dec`

## Requirements
- R1: While rst_ni is 0, pc_sel_o is 4 and every other output is 0, whatever the other inputs are.
- R2: With rst_ni at 1 and irq_i at 1, the outputs are pc_sel_o 6, wa_sel_o 3, wd_sel_o 0 and rf_we_o 1, and every other output is 0. This holds for any instruction.
- R3: With rst_ni at 1 and irq_i at 0, any unsupported instruction gives the same outputs as R2 except that pc_sel_o is 5. Supported opcodes (hex) are 00, 02, 03, 04, 05, 08 to 0F, 23 and 2B. Under opcode 00 the supported function values (hex) are 00, 02, 03, 04, 06, 07, 08, 09 and 20 to 27, 2A, 2B.
- R4: The register ALU operations are add 20, addu 21, sub 22, subu 23, and 24, or 25, xor 26, nor 27, slt 2A and sltu 2B. Each gives pc_sel_o 0, wa_sel_o 0, wd_sel_o 1, rf_we_o 1, a_sel_o 0, b_sel_o 0 and sext_o 0.
- R5: alu_fn_o packs five fields: bit 4 subtract, bits 3:2 variant, bit 1 shift, bit 0 arithmetic. The codes are add/addu/addi/addiu/lw/sw 00001 and sub/subu/beq/bne 10001. Signed compare is 10101 and unsigned compare 11001. The logic operations are and 00000, or 00100, xor 01000 and nor 01100. The shifts are left 00010, logical right 01010 and arithmetic right 01110.
- R6: Function values 00, 02 and 03 shift by the shamt field, with a_sel_o 1. Values 04, 06 and 07 shift by rs, with a_sel_o 0. Both groups use b_sel_o 0 and otherwise follow R4.
- R7: Opcodes 08 to 0E (addi, addiu, slti, sltiu, andi, ori, xori) give pc_sel_o 0, wa_sel_o 1, wd_sel_o 1, rf_we_o 1, a_sel_o 0 and b_sel_o 1. They use the matching R5 code. sext_o is 1 for 08 to 0B and 0 for 0C to 0E.
- R8: lui (0F) gives a_sel_o 2, b_sel_o 1, sext_o 0, the shift-left code, wa_sel_o 1, wd_sel_o 1 and rf_we_o 1.
- R9: lw (23) gives wd_sel_o 2, wa_sel_o 1, rf_we_o 1, b_sel_o 1, sext_o 1 and the add code.
- R10: sw (2B) gives mem_we_o 1, rf_we_o 0, b_sel_o 1, sext_o 1 and the add code.
- R11: beq (04) and bne (05) use the subtract code with b_sel_o 0, sext_o 1 and no writes. pc_sel_o is 1 for beq with z_i 1 and for bne with z_i 0, and 0 otherwise.
- R12: j (02) gives pc_sel_o 2 with no writes. jal (03) gives pc_sel_o 2, wa_sel_o 2, wd_sel_o 0 and rf_we_o 1. Both have alu_fn_o 0 and sext_o 0.
- R13: jr (function 08) gives pc_sel_o 3 with no writes. jalr (09) gives pc_sel_o 3, wa_sel_o 0, wd_sel_o 0 and rf_we_o 1, with alu_fn_o 0.
- R14: Codes are as follows. pc_sel_o: 0 PC+4, 1 branch target, 2 jump field, 3 register, 4 reset vector, 5 illegal vector, 6 interrupt vector. wa_sel_o: 0 rd, 1 rt, 2 r31, 3 r27. wd_sel_o: 0 PC+4, 1 ALU, 2 memory. a_sel_o: 0 rs, 1 shamt, 2 constant 16. b_sel_o: 0 rt, 1 immediate. Any output not named for a case is 0, and wa_sel_o and wd_sel_o are 0 whenever rf_we_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low reset level, highest priority |
| irq_i | input | 1 | Interrupt request, second priority |
| z_i | input | 1 | ALU zero flag |
| opcode_i | input | 6 | Instruction bits 31:26 |
| funct_i | input | 6 | Instruction bits 5:0 |
| pc_sel_o | output | 3 | Next-PC source |
| sext_o | output | 1 | Sign-extend immediate when 1, zero-extend when 0 |
| wa_sel_o | output | 2 | Register write address source |
| wd_sel_o | output | 2 | Register write data source |
| alu_fn_o | output | 5 | ALU function code |
| mem_we_o | output | 1 | Data memory write enable |
| rf_we_o | output | 1 | Register file write enable |
| a_sel_o | output | 2 | ALU operand A source |
| b_sel_o | output | 1 | ALU operand B source |

## Verification
The checker relates outputs only to one another, so it takes for granted that the five inputs are stable 2-state levels and that the outputs have settled from them. The bench applies each input combination on a rising edge and samples on the following falling edge. The sweep covers every opcode, function, reset, interrupt and zero-flag value, so every unsupported encoding and every priority overlap is visited.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ALUFN_W = 5;
  localparam int PCSEL_W = 3;
  localparam int WASEL_W = 2;
  localparam int WDSEL_W = 2;
  localparam int ASEL_W  = 2;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_J     = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL   = 6'h03;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BNE   = 6'h05;
  localparam logic [OP_W-1:0] OP_LUI   = 6'h0f;
  localparam logic [OP_W-1:0] OP_LW    = 6'h23;
  localparam logic [OP_W-1:0] OP_SW    = 6'h2b;

  localparam logic [FN_W-1:0] FN_JR    = 6'h08;
  localparam logic [FN_W-1:0] FN_JALR  = 6'h09;

  localparam logic [ALUFN_W-1:0] ALU_NONE = 5'b00000;
  localparam logic [ALUFN_W-1:0] ALU_ADD  = 5'b00001;
  localparam logic [ALUFN_W-1:0] ALU_SUB  = 5'b10001;
  localparam logic [ALUFN_W-1:0] ALU_SLT  = 5'b10101;
  localparam logic [ALUFN_W-1:0] ALU_SLTU = 5'b11001;
  localparam logic [ALUFN_W-1:0] ALU_SLL  = 5'b00010;

  localparam logic [PCSEL_W-1:0] PC_SEQ  = 3'd0;
  localparam logic [PCSEL_W-1:0] PC_BR   = 3'd1;
  localparam logic [PCSEL_W-1:0] PC_JMP  = 3'd2;
  localparam logic [PCSEL_W-1:0] PC_REG  = 3'd3;
  localparam logic [PCSEL_W-1:0] PC_RST  = 3'd4;
  localparam logic [PCSEL_W-1:0] PC_ILL  = 3'd5;
  localparam logic [PCSEL_W-1:0] PC_IRQ  = 3'd6;

  localparam logic [WASEL_W-1:0] WA_RD  = 2'd0;
  localparam logic [WASEL_W-1:0] WA_RT  = 2'd1;
  localparam logic [WASEL_W-1:0] WA_R31 = 2'd2;
  localparam logic [WASEL_W-1:0] WA_R27 = 2'd3;

  localparam logic [WDSEL_W-1:0] WD_LINK = 2'd0;
  localparam logic [WDSEL_W-1:0] WD_ALU  = 2'd1;
  localparam logic [WDSEL_W-1:0] WD_MEM  = 2'd2;

  localparam logic [ASEL_W-1:0] A_RS    = 2'd0;
  localparam logic [ASEL_W-1:0] A_SHAMT = 2'd1;
  localparam logic [ASEL_W-1:0] A_K16   = 2'd2;

  typedef enum logic [3:0] {
    C_BAD, C_ALU_R, C_SHIFT_I, C_SHIFT_V, C_JR, C_JALR, C_ALU_I,
    C_LUI, C_LW, C_SW, C_BEQ, C_BNE, C_J, C_JAL
  } cls_e;

  typedef struct packed {
    logic [PCSEL_W-1:0] pc_sel;
    logic               sext;
    logic [WASEL_W-1:0] wa_sel;
    logic [WDSEL_W-1:0] wd_sel;
    logic [ALUFN_W-1:0] alu_fn;
    logic               mem_we;
    logic               rf_we;
    logic [ASEL_W-1:0]  a_sel;
    logic               b_sel;
  } ctl_t;
endpackage

// File: rtl/ctl_class_dec.sv
module ctl_class_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  input  logic [FN_W-1:0] funct_i,
  output cls_e            cls_o
);
  always_comb begin
    cls_o = C_BAD;
    case (opcode_i)
      OP_RTYPE: begin
        case (funct_i)
          6'h00, 6'h02, 6'h03: cls_o = C_SHIFT_I;
          6'h04, 6'h06, 6'h07: cls_o = C_SHIFT_V;
          FN_JR:               cls_o = C_JR;
          FN_JALR:             cls_o = C_JALR;
          6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
          6'h2a, 6'h2b:        cls_o = C_ALU_R;
          default:             cls_o = C_BAD;
        endcase
      end
      OP_J:   cls_o = C_J;
      OP_JAL: cls_o = C_JAL;
      OP_BEQ: cls_o = C_BEQ;
      OP_BNE: cls_o = C_BNE;
      6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0e: cls_o = C_ALU_I;
      OP_LUI: cls_o = C_LUI;
      OP_LW:  cls_o = C_LW;
      OP_SW:  cls_o = C_SW;
      default: cls_o = C_BAD;
    endcase
  end
endmodule

// File: rtl/ctl_alu_fn.sv
module ctl_alu_fn
  import ctl_pkg::*;
(
  input  cls_e               cls_i,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic [FN_W-1:0]    funct_i,
  output logic [ALUFN_W-1:0] fn_o
);
  // R-type arithmetic/logic selected by funct[3:0]
  logic [ALUFN_W-1:0] r_fn;
  // immediate forms selected by opcode[2:0]
  logic [ALUFN_W-1:0] i_fn;

  always_comb begin
    case (funct_i[3:0])
      4'h0, 4'h1, 4'h2, 4'h3: r_fn = funct_i[1] ? ALU_SUB : ALU_ADD;
      4'h4, 4'h5, 4'h6, 4'h7: r_fn = {1'b0, funct_i[1:0], 2'b00};
      4'ha:                   r_fn = ALU_SLT;
      4'hb:                   r_fn = ALU_SLTU;
      default:                r_fn = ALU_NONE;
    endcase
  end

  always_comb begin
    case (opcode_i[2:0])
      3'd0, 3'd1: i_fn = ALU_ADD;
      3'd2:       i_fn = ALU_SLT;
      3'd3:       i_fn = ALU_SLTU;
      default:    i_fn = {1'b0, opcode_i[1:0], 2'b00};
    endcase
  end

  always_comb begin
    case (cls_i)
      C_ALU_R:              fn_o = r_fn;
      C_SHIFT_I, C_SHIFT_V: fn_o = {1'b0, funct_i[1:0], 2'b10};
      C_ALU_I:              fn_o = i_fn;
      C_LUI:                fn_o = ALU_SLL;
      C_LW, C_SW:           fn_o = ALU_ADD;
      C_BEQ, C_BNE:         fn_o = ALU_SUB;
      default:              fn_o = ALU_NONE;
    endcase
  end
endmodule

// File: rtl/ctl_rom.sv
module ctl_rom
  import ctl_pkg::*;
(
  input  cls_e               cls_i,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic [ALUFN_W-1:0] fn_i,
  input  logic               z_i,
  output ctl_t               ctl_o
);
  always_comb begin
    ctl_o        = '0;
    ctl_o.alu_fn = fn_i;
    case (cls_i)
      C_ALU_R, C_SHIFT_V: begin
        ctl_o.wd_sel = WD_ALU;
        ctl_o.rf_we  = 1'b1;
      end
      C_SHIFT_I: begin
        ctl_o.wd_sel = WD_ALU;
        ctl_o.rf_we  = 1'b1;
        ctl_o.a_sel  = A_SHAMT;
      end
      C_ALU_I: begin
        ctl_o.wa_sel = WA_RT;
        ctl_o.wd_sel = WD_ALU;
        ctl_o.rf_we  = 1'b1;
        ctl_o.b_sel  = 1'b1;
        ctl_o.sext   = ~opcode_i[2]; // logic immediates zero-extend
      end
      C_LUI: begin
        ctl_o.wa_sel = WA_RT;
        ctl_o.wd_sel = WD_ALU;
        ctl_o.rf_we  = 1'b1;
        ctl_o.b_sel  = 1'b1;
        ctl_o.a_sel  = A_K16;
      end
      C_LW: begin
        ctl_o.wa_sel = WA_RT;
        ctl_o.wd_sel = WD_MEM;
        ctl_o.rf_we  = 1'b1;
        ctl_o.b_sel  = 1'b1;
        ctl_o.sext   = 1'b1;
      end
      C_SW: begin
        ctl_o.mem_we = 1'b1;
        ctl_o.b_sel  = 1'b1;
        ctl_o.sext   = 1'b1;
      end
      C_BEQ, C_BNE: begin
        ctl_o.sext   = 1'b1;
        ctl_o.pc_sel = (z_i ^ (cls_i == C_BNE)) ? PC_BR : PC_SEQ;
      end
      C_J:   ctl_o.pc_sel = PC_JMP;
      C_JAL: begin
        ctl_o.pc_sel = PC_JMP;
        ctl_o.wa_sel = WA_R31;
        ctl_o.wd_sel = WD_LINK;
        ctl_o.rf_we  = 1'b1;
      end
      C_JR:  ctl_o.pc_sel = PC_REG;
      C_JALR: begin
        ctl_o.pc_sel = PC_REG;
        ctl_o.wa_sel = WA_RD;
        ctl_o.wd_sel = WD_LINK;
        ctl_o.rf_we  = 1'b1;
      end
      default: begin
        ctl_o        = '0;
        ctl_o.pc_sel = PC_ILL;
        ctl_o.wa_sel = WA_R27;
        ctl_o.wd_sel = WD_LINK;
        ctl_o.rf_we  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ctl_override.sv
module ctl_override
  import ctl_pkg::*;
(
  input  logic rst_ni,
  input  logic irq_i,
  input  ctl_t ctl_i,
  output ctl_t ctl_o
);
  always_comb begin
    if (!rst_ni) begin
      ctl_o        = '0;
      ctl_o.pc_sel = PC_RST;
    end else if (irq_i) begin
      ctl_o        = '0;
      ctl_o.pc_sel = PC_IRQ;
      ctl_o.wa_sel = WA_R27;
      ctl_o.wd_sel = WD_LINK;
      ctl_o.rf_we  = 1'b1;
    end else begin
      ctl_o = ctl_i;
    end
  end
endmodule

// File: rtl/cpu_ctl_dec.sv
module cpu_ctl_dec
  import ctl_pkg::*;
(
  input  logic               rst_ni,
  input  logic               irq_i,
  input  logic               z_i,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic [FN_W-1:0]    funct_i,
  output logic [PCSEL_W-1:0] pc_sel_o,
  output logic               sext_o,
  output logic [WASEL_W-1:0] wa_sel_o,
  output logic [WDSEL_W-1:0] wd_sel_o,
  output logic [ALUFN_W-1:0] alu_fn_o,
  output logic               mem_we_o,
  output logic               rf_we_o,
  output logic [ASEL_W-1:0]  a_sel_o,
  output logic               b_sel_o
);
  cls_e               cls;
  logic [ALUFN_W-1:0] fn;
  ctl_t               ctl_raw;
  ctl_t               ctl_fin;

  ctl_class_dec u_cls (.opcode_i(opcode_i), .funct_i(funct_i), .cls_o(cls));

  ctl_alu_fn u_fn (.cls_i(cls), .opcode_i(opcode_i), .funct_i(funct_i), .fn_o(fn));

  ctl_rom u_rom (.cls_i(cls), .opcode_i(opcode_i), .fn_i(fn), .z_i(z_i), .ctl_o(ctl_raw));

  ctl_override u_ovr (.rst_ni(rst_ni), .irq_i(irq_i), .ctl_i(ctl_raw), .ctl_o(ctl_fin));

  assign pc_sel_o = ctl_fin.pc_sel;
  assign sext_o   = ctl_fin.sext;
  assign wa_sel_o = ctl_fin.wa_sel;
  assign wd_sel_o = ctl_fin.wd_sel;
  assign alu_fn_o = ctl_fin.alu_fn;
  assign mem_we_o = ctl_fin.mem_we;
  assign rf_we_o  = ctl_fin.rf_we;
  assign a_sel_o  = ctl_fin.a_sel;
  assign b_sel_o  = ctl_fin.b_sel;
endmodule

// File: rtl/cpu_ctl_dec_chk.sv
module cpu_ctl_dec_chk
  import ctl_pkg::*;
(
  input logic [PCSEL_W-1:0] pc_sel_o,
  input logic               sext_o,
  input logic [WASEL_W-1:0] wa_sel_o,
  input logic [WDSEL_W-1:0] wd_sel_o,
  input logic [ALUFN_W-1:0] alu_fn_o,
  input logic               mem_we_o,
  input logic               rf_we_o,
  input logic [ASEL_W-1:0]  a_sel_o,
  input logic               b_sel_o
);
  always_comb begin
    // R1
    reset_quiet_chk: assert (pc_sel_o != PC_RST ||
                             (!mem_we_o && !rf_we_o && alu_fn_o == ALU_NONE))
      else $error("reset vector with active controls");
    // R2
    trap_link_chk: assert (!(pc_sel_o == PC_IRQ || pc_sel_o == PC_ILL) ||
                           (rf_we_o && wa_sel_o == WA_R27 && wd_sel_o == WD_LINK && !mem_we_o))
      else $error("trap without r27 link");
    // R10
    store_no_rf_chk: assert (!mem_we_o ||
                             (!rf_we_o && b_sel_o && sext_o && alu_fn_o == ALU_ADD))
      else $error("store controls inconsistent");
    // R9
    load_path_chk: assert (wd_sel_o != WD_MEM || (rf_we_o && wa_sel_o == WA_RT && b_sel_o))
      else $error("memory write-back inconsistent");
    // R8
    lui_k16_chk: assert (a_sel_o != A_K16 || (b_sel_o && !sext_o && alu_fn_o == ALU_SLL))
      else $error("constant-16 operand misuse");
    // R11
    branch_sub_chk: assert (pc_sel_o != PC_BR || (alu_fn_o == ALU_SUB && !rf_we_o && !mem_we_o))
      else $error("branch target without compare");
    // R14
    code_range_chk: assert (pc_sel_o <= PC_IRQ && wd_sel_o != 2'd3 && a_sel_o != 2'd3)
      else $error("select code out of range");
    // R14
    idle_sel_chk: assert (rf_we_o || (wa_sel_o == WA_RD && wd_sel_o == WD_LINK))
      else $error("write selects set without write");
  end
endmodule

bind cpu_ctl_dec cpu_ctl_dec_chk chk_i (
  .pc_sel_o(pc_sel_o), .sext_o(sext_o), .wa_sel_o(wa_sel_o), .wd_sel_o(wd_sel_o),
  .alu_fn_o(alu_fn_o), .mem_we_o(mem_we_o), .rf_we_o(rf_we_o),
  .a_sel_o(a_sel_o), .b_sel_o(b_sel_o)
);

// File: tb/cpu_ctl_dec_tb.sv
module cpu_ctl_dec_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_ni, irq_i, z_i;
  logic [5:0] opcode_i, funct_i;
  logic [2:0] pc_sel_o;
  logic       sext_o;
  logic [1:0] wa_sel_o, wd_sel_o;
  logic [4:0] alu_fn_o;
  logic       mem_we_o, rf_we_o;
  logic [1:0] a_sel_o;
  logic       b_sel_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_ctl_dec dut_i (.*);

  // packed expectation: pc3 sext1 wa2 wd2 alu5 mem1 rf1 a2 b1 = 18 bits
  typedef struct packed {
    logic [2:0] pc; logic sx; logic [1:0] wa; logic [1:0] wd;
    logic [4:0] fn; logic mw; logic rw; logic [1:0] as; logic bs;
  } exp_t;

  function automatic exp_t trap(input logic [2:0] pc);
    exp_t e = '0;
    e.pc = pc; e.wa = 2'd3; e.rw = 1'b1;
    return e;
  endfunction

  function automatic void model(input logic rn, irq, z, input logic [5:0] op, fn,
                                output exp_t e, output string tag);
    e = trap(3'd5); tag = "R3";
    if (!rn) begin e = '0; e.pc = 3'd4; tag = "R1"; return; end
    if (irq) begin e = trap(3'd6); tag = "R2"; return; end
    if (op == 6'h00) begin
      if (fn inside {6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2a, 6'h2b}) begin
        e = '0; e.wd = 2'd1; e.rw = 1'b1; tag = "R4";
        case (fn)
          6'h20, 6'h21: e.fn = 5'b00001;
          6'h22, 6'h23: e.fn = 5'b10001;
          6'h24: e.fn = 5'b00000;
          6'h25: e.fn = 5'b00100;
          6'h26: e.fn = 5'b01000;
          6'h27: e.fn = 5'b01100;
          6'h2a: e.fn = 5'b10101;
          default: e.fn = 5'b11001;
        endcase
      end else if (fn inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07}) begin
        e = '0; e.wd = 2'd1; e.rw = 1'b1; tag = "R6";
        e.as = (fn < 6'h04) ? 2'd1 : 2'd0;
        e.fn = (fn[1:0] == 2'b00) ? 5'b00010 : (fn[0] ? 5'b01110 : 5'b01010);
      end else if (fn == 6'h08) begin
        e = '0; e.pc = 3'd3; tag = "R13";
      end else if (fn == 6'h09) begin
        e = '0; e.pc = 3'd3; e.rw = 1'b1; tag = "R13";
      end
    end else if (op >= 6'h08 && op <= 6'h0e) begin
      e = '0; e.wa = 2'd1; e.wd = 2'd1; e.rw = 1'b1; e.bs = 1'b1; tag = "R7";
      e.sx = (op <= 6'h0b);
      case (op)
        6'h08, 6'h09: e.fn = 5'b00001;
        6'h0a: e.fn = 5'b10101;
        6'h0b: e.fn = 5'b11001;
        6'h0c: e.fn = 5'b00000;
        6'h0d: e.fn = 5'b00100;
        default: e.fn = 5'b01000;
      endcase
    end else if (op == 6'h0f) begin
      e = '0; e.as = 2'd2; e.bs = 1'b1; e.fn = 5'b00010;
      e.wa = 2'd1; e.wd = 2'd1; e.rw = 1'b1; tag = "R8";
    end else if (op == 6'h23) begin
      e = '0; e.wd = 2'd2; e.wa = 2'd1; e.rw = 1'b1; e.bs = 1'b1; e.sx = 1'b1;
      e.fn = 5'b00001; tag = "R9";
    end else if (op == 6'h2b) begin
      e = '0; e.mw = 1'b1; e.bs = 1'b1; e.sx = 1'b1; e.fn = 5'b00001; tag = "R10";
    end else if (op == 6'h04 || op == 6'h05) begin
      e = '0; e.fn = 5'b10001; e.sx = 1'b1; tag = "R11";
      e.pc = ((op == 6'h04) == z) ? 3'd1 : 3'd0;
    end else if (op == 6'h02) begin
      e = '0; e.pc = 3'd2; tag = "R12";
    end else if (op == 6'h03) begin
      e = '0; e.pc = 3'd2; e.wa = 2'd2; e.rw = 1'b1; tag = "R12";
    end
  endfunction

  task automatic check(input string tag, input exp_t e);
    exp_t got;
    got = {pc_sel_o, sext_o, wa_sel_o, wd_sel_o, alu_fn_o, mem_we_o, rf_we_o, a_sel_o, b_sel_o};
    n_chk++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s op=%h fn=%h rst_n=%b irq=%b z=%b got=%h exp=%h",
               tag, opcode_i, funct_i, rst_ni, irq_i, z_i, got, e);
    end
  endtask

  task automatic apply(input logic rn, irq, z, input logic [5:0] op, fn);
    exp_t  e;
    string tag;
    @(posedge clk);
    rst_ni = rn; irq_i = irq; z_i = z; opcode_i = op; funct_i = fn;
    @(negedge clk);
    model(rn, irq, z, op, fn, e, tag);
    check(tag, e);
  endtask

  initial begin
    rst_ni = 1'b0; irq_i = 1'b0; z_i = 1'b0; opcode_i = '0; funct_i = '0;
    // R1 reset state, with irq and a store pending
    apply(1'b0, 1'b1, 1'b0, 6'h2b, 6'h00);
    // R2 interrupt overrides a jal
    apply(1'b1, 1'b1, 1'b1, 6'h03, 6'h00);
    // R11 branch corners
    apply(1'b1, 1'b0, 1'b1, 6'h04, 6'h3f);
    apply(1'b1, 1'b0, 1'b0, 6'h05, 6'h3f);
    // R3 unsupported funct and opcode
    apply(1'b1, 1'b0, 1'b0, 6'h00, 6'h01);
    apply(1'b1, 1'b0, 1'b0, 6'h3f, 6'h20);
    // full sweep: R4 R5 R6 R7 R8 R9 R10 R12 R13 R14
    for (int r = 0; r < 2; r++)
      for (int q = 0; q < 2; q++)
        for (int zz = 0; zz < 2; zz++)
          for (int o = 0; o < 64; o++)
            for (int f = 0; f < 64; f++)
              apply(r[0], q[0], zz[0], o[5:0], f[5:0]);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule